// File: doc/BRIEF.md
# Transactional Commit Store Queue

This block collects the speculative stores of a single transaction and holds them until the transaction commits. Each store that touches shared data is written into an in-order queue as an address and value pair. Stores to words marked as thread-local never enter the queue. Nothing reaches the shared bus while the transaction runs.

To commit, the core pulses a start input. The block then requests the shared bus and waits for a grant. Once granted, it replays every queued store in the order it was written, using a valid/ready handshake. After the last store has been accepted, it pulses a single flash-clear strobe toward the cache. That strobe commits all thread-local words by clearing their local marks, so the local data needs no bus traffic. One cycle after the strobe, a done pulse ends the commit.

An abort empties the queue in one cycle from any state and returns the block to idle.

Top module: `commit_store_queue`

## Requirements
- R1: After reset, st_stall_o, bus_req_o, bus_valid_o, sl_clear_o and commit_done_o are all low and the queue is empty.
- R2: In idle, a store with st_valid_i high, st_local_i low and st_stall_o low is appended to the queue.
- R3: While no commit is in progress, bus_valid_o and bus_req_o stay low whatever stores arrive.
- R4: A store with st_local_i high is never queued, so it is never replayed on the bus.
- R5: During replay, queued stores appear on bus_addr_o/bus_data_o in the same order they were accepted, each exactly once.
- R6: When the queue holds DEPTH entries, st_stall_o is high and a further store is not accepted. Entries already queued are kept.
- R7: While bus_valid_o is high and bus_ready_i is low, bus_valid_o, bus_addr_o and bus_data_o hold their values into the next cycle.
- R8: bus_req_o rises one cycle after commit_start_i is sampled in idle. bus_valid_o is never high without bus_req_o, and no entry is offered before bus_gnt_i.
- R9: sl_clear_o is a one-cycle pulse in the cycle right after the last entry is accepted. commit_done_o is a one-cycle pulse in the cycle right after sl_clear_o.
- R10: A commit with an empty queue still pulses sl_clear_o once, and then commit_done_o, with no bus transfer.
- R11: abort_i discards the whole queue in one cycle from any state. In the next cycle bus_valid_o, bus_req_o and st_stall_o are low, and a following commit replays nothing.
- R12: From the cycle after commit_start_i until the block is back in idle, st_stall_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid_i | input | 1 | Store presented by the core |
| st_addr_i | input | ADDR_W | Store word address |
| st_data_i | input | DATA_W | Store value |
| st_local_i | input | 1 | Word is thread-local; do not queue |
| st_stall_o | output | 1 | Store not accepted this cycle (queue full or commit running) |
| commit_start_i | input | 1 | Begin commit of the current transaction |
| abort_i | input | 1 | Discard the transaction's queued stores |
| bus_req_o | output | 1 | Request ownership of the shared bus |
| bus_gnt_i | input | 1 | Bus ownership granted |
| bus_valid_o | output | 1 | Replay write offered on the bus |
| bus_addr_o | output | ADDR_W | Replay write address |
| bus_data_o | output | DATA_W | Replay write value |
| bus_ready_i | input | 1 | Bus accepts the offered write |
| sl_clear_o | output | 1 | Flash-clear of thread-local marks in the cache |
| commit_done_o | output | 1 | Commit finished |

## Verification
The hardest situation to reach is a handshake that lands on the very last entry while the bus is throttled. Here the end of replay, the local-clear strobe and the done pulse have to line up with the final acceptance. The stimulus walks a table of mixed local and shared stores, then replays them under a ready pattern that only accepts every second or third cycle. Each held offer is compared with the one before it, and the position of sl_clear_o is checked against the cycle of the last acceptance. An abort in the middle of replay is forced by counting accepted entries and pulsing abort_i after the second one.

// File: rtl/csq_pkg.sv
package csq_pkg;
  typedef enum logic [2:0] {
    CS_IDLE   = 3'd0,
    CS_WAIT   = 3'd1,
    CS_REPLAY = 3'd2,
    CS_CLEAR  = 3'd3,
    CS_DONE   = 3'd4
  } csq_state_e;
endpackage

// File: rtl/csq_ram.sv
module csq_ram #(
  parameter int WIDTH = 64,
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/csq_fifo_ctrl.sv
module csq_fifo_ctrl #(
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          wr_en,
  input  logic          rd_en,
  output logic [AW-1:0] waddr,
  output logic [AW-1:0] raddr,
  output logic          full,
  output logic          empty
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);

  logic [CW-1:0] count;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      waddr <= '0;
      raddr <= '0;
      count <= '0;
    end else begin
      if (wr_en) waddr <= (waddr == LAST) ? '0 : waddr + 1'b1;
      if (rd_en) raddr <= (raddr == LAST) ? '0 : raddr + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign full  = (count == FULLC);
  assign empty = (count == '0);

  // R6: the writer never pushes into a full queue
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !full);
  // R5: the reader never pops an empty queue
  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> !empty);
endmodule

// File: rtl/csq_drain.sv
module csq_drain (
  input  logic clk,
  input  logic rst,
  input  logic flush,
  input  logic replay_on,
  input  logic fifo_empty,
  input  logic bus_ready,
  output logic rd_en,
  output logic out_valid
);
  assign rd_en = replay_on && !flush && !fifo_empty && (!out_valid || bus_ready);

  always_ff @(posedge clk) begin
    if (rst || flush)          out_valid <= 1'b0;
    else if (rd_en)            out_valid <= 1'b1;
    else if (bus_ready)        out_valid <= 1'b0;
  end

  // R5: a new entry is offered only while replay runs
  assert_offer_in_replay_R5: assert property (@(posedge clk) disable iff (rst || flush)
    $rose(out_valid) |-> $past(replay_on));
endmodule

// File: rtl/csq_seq.sv
module csq_seq
  import csq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       abort,
  input  logic       commit_start,
  input  logic       gnt,
  input  logic       fifo_empty,
  input  logic       out_valid,
  input  logic       bus_ready,
  output csq_state_e state,
  output logic       bus_req,
  output logic       sl_clear,
  output logic       done
);
  csq_state_e state_n;

  always_comb begin
    state_n = state;
    unique case (state)
      CS_IDLE:   if (commit_start) state_n = CS_WAIT;
      CS_WAIT:   if (gnt) state_n = CS_REPLAY;
      CS_REPLAY: if (fifo_empty && (!out_valid || bus_ready)) state_n = CS_CLEAR;
      CS_CLEAR:  state_n = CS_DONE;
      CS_DONE:   state_n = CS_IDLE;
      default:   state_n = CS_IDLE;
    endcase
    if (abort) state_n = CS_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= CS_IDLE;
      bus_req  <= 1'b0;
      sl_clear <= 1'b0;
      done     <= 1'b0;
    end else begin
      state    <= state_n;
      bus_req  <= (state_n == CS_WAIT) || (state_n == CS_REPLAY) || (state_n == CS_CLEAR);
      sl_clear <= (state_n == CS_CLEAR);
      done     <= (state_n == CS_DONE);
    end
  end

  // R9: the clear strobe lasts one cycle
  assert_clear_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    sl_clear |=> !sl_clear);
  // R9: done follows the clear strobe
  assert_done_after_clear_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(sl_clear));
  // R8: bus request follows a commit start in idle
  assert_req_after_start_R8: assert property (@(posedge clk) disable iff (rst || abort)
    (state == CS_IDLE && commit_start) |=> bus_req);
endmodule

// File: rtl/commit_store_queue.sv
module commit_store_queue
  import csq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              st_valid_i,
  input  logic [ADDR_W-1:0] st_addr_i,
  input  logic [DATA_W-1:0] st_data_i,
  input  logic              st_local_i,
  output logic              st_stall_o,
  input  logic              commit_start_i,
  input  logic              abort_i,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic              bus_valid_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_data_o,
  input  logic              bus_ready_i,
  output logic              sl_clear_o,
  output logic              commit_done_o
);
  localparam int ENT_W = ADDR_W + DATA_W;
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  csq_state_e    state;
  logic          fifo_full, fifo_empty;
  logic          wr_en, rd_en, out_valid;
  logic [AW-1:0] waddr, raddr;
  logic [ENT_W-1:0] ram_q;

  assign st_stall_o = (state != CS_IDLE) || fifo_full;
  assign wr_en      = st_valid_i && !st_local_i && !st_stall_o && !abort_i;

  csq_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .flush(abort_i),
    .wr_en(wr_en), .rd_en(rd_en),
    .waddr(waddr), .raddr(raddr),
    .full(fifo_full), .empty(fifo_empty)
  );

  csq_ram #(.WIDTH(ENT_W), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .we(wr_en), .waddr(waddr), .wdata({st_addr_i, st_data_i}),
    .re(rd_en), .raddr(raddr), .rdata(ram_q)
  );

  csq_drain u_drain (
    .clk(clk), .rst(rst), .flush(abort_i),
    .replay_on(state == CS_REPLAY), .fifo_empty(fifo_empty),
    .bus_ready(bus_ready_i), .rd_en(rd_en), .out_valid(out_valid)
  );

  csq_seq u_seq (
    .clk(clk), .rst(rst), .abort(abort_i), .commit_start(commit_start_i),
    .gnt(bus_gnt_i), .fifo_empty(fifo_empty), .out_valid(out_valid),
    .bus_ready(bus_ready_i), .state(state), .bus_req(bus_req_o),
    .sl_clear(sl_clear_o), .done(commit_done_o)
  );

  assign bus_valid_o = out_valid;
  assign bus_addr_o  = ram_q[ENT_W-1:DATA_W];
  assign bus_data_o  = ram_q[DATA_W-1:0];

  // R7: an offered write is held until accepted
  assert_hold_payload_R7: assert property (@(posedge clk) disable iff (rst || abort_i)
    (bus_valid_o && !bus_ready_i) |=> (bus_valid_o && $stable(bus_addr_o) && $stable(bus_data_o)));
  // R8: no bus write without ownership request
  assert_valid_needs_req_R8: assert property (@(posedge clk) disable iff (rst)
    bus_valid_o |-> bus_req_o);
  // R3: no bus activity while idle
  assert_quiet_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (state == CS_IDLE) |-> (!bus_valid_o && !bus_req_o));
  // R4: local stores are never written into the queue
  assert_local_dropped_R4: assert property (@(posedge clk) disable iff (rst)
    (st_valid_i && st_local_i) |-> !wr_en);
  // R11: abort empties everything in one cycle
  assert_abort_flush_R11: assert property (@(posedge clk) disable iff (rst)
    abort_i |=> (!bus_valid_o && !bus_req_o && !st_stall_o));
endmodule

// File: tb/tb_commit_store_queue.sv
`timescale 1ns/1ps
module tb_commit_store_queue;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int DEPTH = 8;
  localparam int NVEC = 10;

  // each entry: {local, addr, data}
  localparam logic [64:0] VEC [NVEC] = '{
    {1'b0, 32'h0000_0100, 32'hA000_0001},
    {1'b1, 32'h0000_F000, 32'hDEAD_0001},
    {1'b0, 32'h0000_0104, 32'hA000_0002},
    {1'b0, 32'h0000_0200, 32'hB000_0003},
    {1'b1, 32'h0000_F004, 32'hDEAD_0002},
    {1'b0, 32'h0000_0100, 32'hC000_0004},
    {1'b0, 32'h0000_0300, 32'hD000_0005},
    {1'b1, 32'h0000_F008, 32'hDEAD_0003},
    {1'b0, 32'h0000_0204, 32'hE000_0006},
    {1'b0, 32'h0000_0108, 32'hF000_0007}
  };

  logic clk = 0, rst = 1;
  logic st_valid = 0, st_local = 0, commit_start = 0, abort = 0, gnt = 0, ready = 0;
  logic [AW-1:0] st_addr = '0;
  logic [DW-1:0] st_data = '0;
  logic st_stall, bus_req, bus_valid, sl_clear, done;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_data;

  int n_tests = 0, n_fail = 0, nexp = 0;
  logic [AW-1:0] exp_addr [16];
  logic [DW-1:0] exp_data [16];

  always #2 clk = ~clk;

  commit_store_queue #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .st_valid_i(st_valid), .st_addr_i(st_addr),
    .st_data_i(st_data), .st_local_i(st_local), .st_stall_o(st_stall),
    .commit_start_i(commit_start), .abort_i(abort), .bus_req_o(bus_req),
    .bus_gnt_i(gnt), .bus_valid_o(bus_valid), .bus_addr_o(bus_addr),
    .bus_data_o(bus_data), .bus_ready_i(ready), .sl_clear_o(sl_clear),
    .commit_done_o(done)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(input bit loc, input logic [AW-1:0] a, input logic [DW-1:0] d, input bit expect_accept);
    st_valid = 1; st_local = loc; st_addr = a; st_data = d;
    if (expect_accept && !loc) begin
      exp_addr[nexp] = a; exp_data[nexp] = d; nexp++;
    end
    @(posedge clk); @(negedge clk);
    st_valid = 0; st_local = 0;
    chk(!bus_valid && !bus_req, "R3", {62'd0, bus_valid, bus_req}, 64'd0);
  endtask

  task automatic run_commit(input int pat, input string tag);
    int got = 0;
    int clr_cnt = 0;
    bit clr_prev = 0;
    bit held = 0;
    bit fin = 0;
    logic [AW-1:0] pa = '0;
    logic [DW-1:0] pd = '0;
    commit_start = 1;
    @(posedge clk); @(negedge clk);
    commit_start = 0;
    chk(bus_req == 1'b1, {"R8 req ", tag}, {63'd0, bus_req}, 64'd1);
    chk(st_stall == 1'b1, {"R12 stall ", tag}, {63'd0, st_stall}, 64'd1);
    for (int w = 0; w < 2; w++) begin
      @(posedge clk); @(negedge clk);
      chk(bus_valid == 1'b0, {"R8 no offer before grant ", tag}, {63'd0, bus_valid}, 64'd0);
    end
    gnt = 1;
    for (int cyc = 0; cyc < 300 && !fin; cyc++) begin
      bit r;
      r = (pat == 0) ? 1'b1 : ((cyc % pat) == pat - 1);
      if (held)
        chk(bus_valid && bus_addr == pa && bus_data == pd, {"R7 ", tag}, {bus_addr, bus_data}, {pa, pd});
      if (bus_valid && r) begin
        if (got < nexp)
          chk(bus_addr == exp_addr[got] && bus_data == exp_data[got], {"R5 order ", tag},
              {bus_addr, bus_data}, {exp_addr[got], exp_data[got]});
        else
          chk(1'b0, {"R5 extra write ", tag}, {bus_addr, bus_data}, 64'd0);
        got++;
      end
      held = bus_valid && !r;
      pa = bus_addr; pd = bus_data;
      if (done || clr_prev)
        chk(done == clr_prev, {"R9 done after clear ", tag}, {63'd0, done}, {63'd0, clr_prev});
      if (done) fin = 1;
      if (sl_clear) begin
        clr_cnt++;
        chk(got == nexp && !bus_valid, {"R9 clear after last ", tag}, 64'(got), 64'(nexp));
      end
      clr_prev = sl_clear;
      ready = r;
      @(posedge clk); @(negedge clk);
    end
    ready = 0; gnt = 0;
    chk(got == nexp, {"R5 count ", tag}, 64'(got), 64'(nexp));
    chk(clr_cnt == 1, {"R9 R10 clear pulses ", tag}, 64'(clr_cnt), 64'd1);
    chk(fin, {"R9 done seen ", tag}, {63'd0, fin}, 64'd1);
    nexp = 0;
    @(posedge clk); @(negedge clk);
    chk(!st_stall, {"R12 released ", tag}, {63'd0, st_stall}, 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 0;
    chk(!st_stall && !bus_req && !bus_valid && !sl_clear && !done, "R1 reset",
        {59'd0, st_stall, bus_req, bus_valid, sl_clear, done}, 64'd0);

    // R10: empty commit straight after reset
    run_commit(0, "empty");

    // table walk: mixed local/shared stores, throttled replay (R2 R3 R4 R5 R7)
    for (int i = 0; i < NVEC; i++) begin
      chk(!st_stall, "R2 accept", {63'd0, st_stall}, 64'd0);
      push(VEC[i][64], VEC[i][63:32], VEC[i][31:0], 1'b1);
    end
    run_commit(2, "table p2");

    // same table, slower bus
    for (int i = 0; i < NVEC; i++) push(VEC[i][64], VEC[i][63:32], VEC[i][31:0], 1'b1);
    run_commit(3, "table p3");

    // R4: only local stores -> nothing on the bus
    for (int i = 0; i < 3; i++) push(1'b1, 32'h0000_F100 + 32'(i), 32'h5555_0000 + 32'(i), 1'b1);
    run_commit(0, "all local R4");

    // R6: fill to DEPTH, extra store held off, queued entries kept
    for (int i = 0; i < DEPTH; i++) push(1'b0, 32'h0000_4000 + 32'(i*4), 32'h7700_0000 + 32'(i), 1'b1);
    chk(st_stall == 1'b1, "R6 full stall", {63'd0, st_stall}, 64'd1);
    push(1'b0, 32'h0000_9999, 32'hBAD0_BAD0, 1'b0);
    chk(st_stall == 1'b1, "R6 still full", {63'd0, st_stall}, 64'd1);
    run_commit(0, "full R6");

    // R11: abort while idle with queued entries
    for (int i = 0; i < 3; i++) push(1'b0, 32'h0000_6000 + 32'(i), 32'h6600_0000 + 32'(i), 1'b0);
    abort = 1;
    @(posedge clk); @(negedge clk);
    abort = 0;
    chk(!bus_valid && !bus_req && !st_stall, "R11 idle abort",
        {61'd0, bus_valid, bus_req, st_stall}, 64'd0);
    run_commit(0, "after abort R11");

    // R11: abort in the middle of replay
    for (int i = 0; i < 5; i++) push(1'b0, 32'h0000_8000 + 32'(i), 32'h8800_0000 + 32'(i), 1'b0);
    commit_start = 1;
    @(posedge clk); @(negedge clk);
    commit_start = 0; gnt = 1; ready = 1;
    begin
      int acc = 0;
      for (int c = 0; c < 50 && acc < 2; c++) begin
        if (bus_valid) acc++;
        @(posedge clk); @(negedge clk);
      end
      chk(acc == 2, "R11 partial replay", 64'(acc), 64'd2);
    end
    ready = 0; abort = 1;
    @(posedge clk); @(negedge clk);
    abort = 0; gnt = 0;
    chk(!bus_valid && !bus_req && !st_stall, "R11 replay abort",
        {61'd0, bus_valid, bus_req, st_stall}, 64'd0);
    run_commit(0, "after replay abort R11");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule